// File: doc/BRIEF.md
# Stereo Serial Audio Framer

This block moves packed stereo audio between a 32-bit word interface and a three-wire serial audio link made of a channel-select line, a data-out line and a data-in line. Each word holds two samples. The left sample is in the lower half-word and the right sample is in the upper half-word. Each sample is aligned to the top of its 16-bit field. On the transmit side, the block takes one word per frame and shifts both samples out, most significant bit first. On the receive side, it samples the incoming line, rebuilds a word in the same layout, and hands the word over once the right sample is complete.

The bit clock itself is produced elsewhere. The block runs on the system clock and receives two one-cycle strobes: one for each falling edge of the bit clock and one for each rising edge. Outgoing data and the channel-select line change only on falling strobes. Incoming data is captured only on rising strobes. A format input chooses between two framings: classic I2S (select low for left, data delayed by one bit) and MSB-justified (select high for left, data aligned with the select edge). The block samples this input once per frame.

Top module: `stereo_ser_link`

## Requirements
- R1: A word carries the left sample in bits [15:0] and the right sample in bits [31:16]. With the default 16-bit sample width, all 16 bits of a field are sample bits, sent and received MSB (field bit 15) first.
- R2: A frame is 64 bit periods. The position advances on every falling strobe, and the first falling strobe after reset starts a frame. Rising and falling strobes never occur in the same cycle. The select line changes only on a falling strobe, and only when entering position 0 or position 32.
- R3: With `fmt_sel` = 0 (I2S), the select line is low for the left half (positions 0–31) and high for the right half. A sample's MSB is sent at position 1 of its half, and position 0 of each half carries a zero.
- R4: With `fmt_sel` = 1 (MSB-justified), the select line is high for the left half and low for the right half. A sample's MSB is sent at position 0 of its half.
- R5: `fmt_sel` is sampled only on the falling strobe that starts a frame. A change at any other time affects neither that frame's transmit nor its receive timing.
- R6: After the 16 sample bits of a half, the data-out line is zero for the rest of that half. The data-out line changes only on a falling strobe.
- R7: `tx_ready` is high only during the cycle of the falling strobe that starts a frame. If `tx_valid` is high in that cycle, `tx_data` becomes the word sent in the frame.
- R8: If `tx_valid` is low when a frame starts, the whole frame is sent as zeros and `tx_underrun` pulses high for the one cycle after that strobe.
- R9: `ser_din` is captured on rising strobes at the same positions the transmitter uses for the current format. Bits at any other position are ignored, and the word is assembled in the R1 layout.
- R10: `rx_valid` pulses for exactly one cycle, in the cycle after the rising strobe that captures the last right-sample bit (position 48 in I2S, 47 in MSB-justified). `rx_data` holds the assembled word from that cycle onward.
- R11: If `rx_ready` is low while `rx_valid` is high, the word is dropped and `rx_overrun` pulses high in the following cycle. Otherwise `rx_overrun` stays low.
- R12: While `rst_n` is low, the block returns to position 63 of an I2S frame: select high, data-out low, and all flags and valids low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk_rise | input | 1 | One-cycle strobe at each rising bit-clock edge |
| bclk_fall | input | 1 | One-cycle strobe at each falling bit-clock edge |
| fmt_sel | input | 1 | Framing select: 0 = I2S, 1 = MSB-justified |
| tx_data | input | 32 | Word to send; left in [15:0], right in [31:16] |
| tx_valid | input | 1 | `tx_data` is available |
| tx_ready | output | 1 | Word is taken in this cycle when `tx_valid` is high |
| tx_underrun | output | 1 | One-cycle pulse: a frame started with no word available |
| ser_sync | output | 1 | Channel-select line to the codec |
| ser_dout | output | 1 | Serial data to the codec |
| ser_din | input | 1 | Serial data from the codec |
| rx_data | output | 32 | Last assembled received word |
| rx_valid | output | 1 | One-cycle pulse: `rx_data` holds a new word |
| rx_ready | input | 1 | Consumer accepts the word during `rx_valid` |
| rx_overrun | output | 1 | One-cycle pulse: a received word was dropped |

## Verification
The assertions assume that rising and falling strobes never share a cycle. They also assume that the strobes are spaced well apart, so that a received word's valid pulse cannot be followed by another one in the next cycle. The bench meets both assumptions by producing each bit period as four system cycles: a falling strobe, an idle cycle, a rising strobe, and another idle cycle. Format, transmit availability, consumer readiness and word contents are drawn at random and change in the middle of frames. A few directed frames cover all-ones data, the lone MSB and LSB, an underrun and an overrun.

// File: rtl/ser_link_pkg.sv
// Package: shared frame geometry, format encoding and the slot decoder used
// by both the transmit and the receive side.
// Assumes a 64-bit-period frame split into two 32-bit-period halves, with
// left first, and one 16-bit field per channel in the packed word.
package ser_link_pkg;

    localparam int FIELD_W = 16;
    localparam int HALF_W  = 32;
    localparam int FRAME_W = 2 * HALF_W;
    localparam int POS_W   = $clog2(FRAME_W);
    localparam int IDX_W   = $clog2(FIELD_W);
    localparam int WORD_W  = 2 * FIELD_W;

    typedef enum logic {
        FMT_I2S  = 1'b0,
        FMT_MSBJ = 1'b1
    } fmt_e;

    typedef struct packed {
        logic             hit;     // position carries a sample bit
        logic             right;   // channel: 1 = right half-word
        logic [IDX_W-1:0] bit_idx; // bit inside the 16-bit field
    } slot_t;

    // Maps a frame position to the sample bit it carries under a format.
    function automatic slot_t decode_slot(input logic [POS_W-1:0] pos,
                                          input fmt_e fmt,
                                          input int sample_w);
        slot_t s;
        int    k;
        k = int'(pos[POS_W-2:0]);
        if (fmt == FMT_I2S) begin
            k = k - 1;
        end
        s.hit     = (k >= 0) && (k < sample_w);
        s.right   = pos[POS_W-1];
        s.bit_idx = s.hit ? IDX_W'(FIELD_W - 1 - k) : '0;
        return s;
    endfunction

    // Level of the channel-select line at a frame position.
    function automatic logic sync_level(input logic [POS_W-1:0] pos,
                                        input fmt_e fmt);
        return (fmt == FMT_I2S) ? pos[POS_W-1] : ~pos[POS_W-1];
    endfunction

endpackage

// File: rtl/ser_link_frame.sv
// Frame position counter and per-frame format latch.
// Advances one position on every falling strobe. The reset value is the last
// position, so the first strobe opens a frame. The format is latched only at
// frame start. The *_n outputs are the values that take effect at this edge.
module ser_link_frame
    import ser_link_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_fall,
    input  logic             fmt_sel,
    output logic [POS_W-1:0] pos_q,
    output logic [POS_W-1:0] pos_n,
    output logic             frame_start,
    output fmt_e             fmt_q,
    output fmt_e             fmt_n
);

    // Next-state view of the position and the format.
    always_comb begin
        frame_start = bclk_fall && (pos_q == '1);
        pos_n       = bclk_fall ? pos_q + 1'b1 : pos_q;
        fmt_n       = frame_start ? fmt_e'(fmt_sel) : fmt_q;
    end

    // Position and format registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '1;
            fmt_q <= FMT_I2S;
        end else begin
            pos_q <= pos_n;
            fmt_q <= fmt_n;
        end
    end

    // R2: a frame start always lands on position zero.
    p_frame_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (pos_q == '0));

endmodule

// File: rtl/ser_link_tx.sv
// Transmit side: takes one word per frame, then drives data and select.
// Both outputs are registered and update only on falling strobes. They are
// computed from the next position and format, so the MSB-justified MSB
// leaves on the same strobe that moves the select line.
module ser_link_tx
    import ser_link_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_fall,
    input  logic              frame_start,
    input  logic [POS_W-1:0]  pos_n,
    input  fmt_e              fmt_n,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              tx_underrun,
    output logic              ser_dout,
    output logic              ser_sync
);

    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] word_n;
    slot_t             slot;
    logic              bit_n;

    // Word selection and the bit for the position being entered.
    always_comb begin
        tx_ready = frame_start;
        if (frame_start) begin
            word_n = tx_valid ? tx_data : '0;
        end else begin
            word_n = word_q;
        end
        slot  = decode_slot(pos_n, fmt_n, SAMPLE_W);
        bit_n = slot.hit ? word_n[{slot.right, slot.bit_idx}] : 1'b0;
    end

    // Word, data and select registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q   <= '0;
            ser_dout <= 1'b0;
            ser_sync <= 1'b1;
        end else if (bclk_fall) begin
            word_q   <= word_n;
            ser_dout <= bit_n;
            ser_sync <= sync_level(pos_n, fmt_n);
        end
    end

    // Underrun pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_underrun <= 1'b0;
        end else begin
            tx_underrun <= frame_start && !tx_valid;
        end
    end

    // R8: an underrun frame carries an all-zero word.
    p_underrun_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_underrun |-> (word_q == '0));

    // R6: the data line moves only after a falling strobe.
    p_dout_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ser_dout) |-> $past(bclk_fall));

    // R2: the select line moves only after a falling strobe.
    p_sync_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ser_sync) |-> $past(bclk_fall));

endmodule

// File: rtl/ser_link_rx.sv
// Receive side: captures the data line on rising strobes at the positions the
// current frame's format assigns to sample bits, and builds the packed word.
// When the last right bit is captured, the word is presented for one cycle.
// If the consumer is not ready in that cycle, an overrun is flagged.
// Field bits below the sample width are never written, so they stay zero.
module ser_link_rx
    import ser_link_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_rise,
    input  logic              ser_din,
    input  logic [POS_W-1:0]  pos_q,
    input  fmt_e              fmt_q,
    input  logic              rx_ready,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_overrun
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FIELD_W - SAMPLE_W);

    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] acc_n;
    slot_t             slot;
    logic              cap;
    logic              done;

    // Bit capture into the accumulator, and detection of the final bit.
    always_comb begin
        slot  = decode_slot(pos_q, fmt_q, SAMPLE_W);
        cap   = bclk_rise && slot.hit;
        done  = cap && slot.right && (slot.bit_idx == LAST_IDX);
        acc_n = acc_q;
        if (cap) begin
            acc_n[{slot.right, slot.bit_idx}] = ser_din;
        end
    end

    // Accumulator, output word and handshake registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q      <= '0;
            rx_data    <= '0;
            rx_valid   <= 1'b0;
            rx_overrun <= 1'b0;
        end else begin
            acc_q      <= acc_n;
            rx_valid   <= done;
            rx_overrun <= rx_valid && !rx_ready;
            if (done) begin
                rx_data <= acc_n;
            end
        end
    end

    // R10: a received word is offered for a single cycle.
    p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R11: an overrun never coincides with a fresh word.
    p_overrun_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |-> !rx_valid);

endmodule

// File: rtl/stereo_ser_link.sv
// Top of the stereo serial audio framer. It connects the frame counter and the
// transmit and receive sides. Assumes that the bit-clock strobes come from an
// external divider, that they are one cycle wide, and that rising and falling
// strobes alternate without ever sharing a cycle.
module stereo_ser_link
    import ser_link_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bclk_rise,
    input  logic        bclk_fall,
    input  logic        fmt_sel,
    input  logic [31:0] tx_data,
    input  logic        tx_valid,
    output logic        tx_ready,
    output logic        tx_underrun,
    output logic        ser_sync,
    output logic        ser_dout,
    input  logic        ser_din,
    output logic [31:0] rx_data,
    output logic        rx_valid,
    input  logic        rx_ready,
    output logic        rx_overrun
);

    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] pos_n;
    logic             frame_start;
    fmt_e             fmt_q;
    fmt_e             fmt_n;

    ser_link_frame i_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .bclk_fall   (bclk_fall),
        .fmt_sel     (fmt_sel),
        .pos_q       (pos_q),
        .pos_n       (pos_n),
        .frame_start (frame_start),
        .fmt_q       (fmt_q),
        .fmt_n       (fmt_n)
    );

    ser_link_tx #(.SAMPLE_W(SAMPLE_W)) i_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .bclk_fall   (bclk_fall),
        .frame_start (frame_start),
        .pos_n       (pos_n),
        .fmt_n       (fmt_n),
        .tx_data     (tx_data),
        .tx_valid    (tx_valid),
        .tx_ready    (tx_ready),
        .tx_underrun (tx_underrun),
        .ser_dout    (ser_dout),
        .ser_sync    (ser_sync)
    );

    ser_link_rx #(.SAMPLE_W(SAMPLE_W)) i_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk_rise  (bclk_rise),
        .ser_din    (ser_din),
        .pos_q      (pos_q),
        .fmt_q      (fmt_q),
        .rx_ready   (rx_ready),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .rx_overrun (rx_overrun)
    );

    // R2: the two strobes are exclusive (input assumption).
    p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bclk_rise && bclk_fall));

    // R2: the select line toggles only at a half boundary.
    p_sync_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ser_sync) |-> ((pos_q == POS_W'(0)) || (pos_q == POS_W'(HALF_W))));

endmodule

// File: tb/test_stereo_ser_link.sv
// Bench: one bit period is four system cycles (fall, idle, rise, idle). A
// codec model drives ser_din, and a reference model predicts every output.
module test_stereo_ser_link;

    localparam int SW = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bclk_rise;
    logic        bclk_fall;
    logic        fmt_sel;
    logic [31:0] tx_data;
    logic        tx_valid;
    logic        tx_ready;
    logic        tx_underrun;
    logic        ser_sync;
    logic        ser_dout;
    logic        ser_din;
    logic [31:0] rx_data;
    logic        rx_valid;
    logic        rx_ready;
    logic        rx_overrun;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    stereo_ser_link i_stereo_ser_link (
        .clk (clk), .rst_n (rst_n), .bclk_rise (bclk_rise), .bclk_fall (bclk_fall),
        .fmt_sel (fmt_sel), .tx_data (tx_data), .tx_valid (tx_valid),
        .tx_ready (tx_ready), .tx_underrun (tx_underrun), .ser_sync (ser_sync),
        .ser_dout (ser_dout), .ser_din (ser_din), .rx_data (rx_data),
        .rx_valid (rx_valid), .rx_ready (rx_ready), .rx_overrun (rx_overrun)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: act=%0d cycles exp<=150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp = n_cmp + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // Reference: offset of a position inside its sample, by format.
    function automatic int ref_k(input int pos, input bit fmt);
        int k = pos % 32;
        if (fmt == 1'b0) k = k - 1;
        return k;
    endfunction

    function automatic bit ref_bit(input logic [31:0] w, input int pos, input bit fmt);
        int k = ref_k(pos, fmt);
        if (k < 0 || k >= SW) return 1'b0;
        return w[(pos >= 32 ? 16 : 0) + 15 - k];
    endfunction

    function automatic bit ref_sync(input int pos, input bit fmt);
        return (fmt == 1'b0) ? (pos >= 32) : (pos < 32);
    endfunction

    function automatic bit ref_last(input int pos, input bit fmt);
        return (pos >= 32) && (ref_k(pos, fmt) == SW - 1);
    endfunction

    int          bpos = 63;
    int          frame_no = 0;
    bit          fmt_frame = 1'b0;
    logic [31:0] tx_frame = '0;
    logic [31:0] rx_frame = '0;
    logic [31:0] rx_next = '0;
    bit          exp_ovr = 1'b0;

    // Inputs for the next frame: directed first, random afterwards.
    task automatic prepare(input int n);
        case (n)
            0: begin fmt_sel = 1'b1; tx_valid = 1'b1; tx_data = 32'hFFFF_FFFF;
                     rx_next = 32'h8001_8001; rx_ready = 1'b1; end
            1: begin fmt_sel = 1'b0; tx_valid = 1'b0; tx_data = 32'hDEAD_BEEF;
                     rx_next = 32'hFFFF_FFFF; rx_ready = 1'b1; end
            2: begin fmt_sel = 1'b0; tx_valid = 1'b1; tx_data = 32'h0001_8000;
                     rx_next = 32'h1234_ABCD; rx_ready = 1'b0; end
            3: begin fmt_sel = 1'b1; tx_valid = 1'b1; tx_data = 32'h8000_0001;
                     rx_next = 32'h0000_0001; rx_ready = 1'b1; end
            default: begin
                fmt_sel  = 1'($urandom);
                tx_valid = ($urandom % 8) != 0;
                tx_data  = $urandom;
                rx_next  = $urandom;
                rx_ready = ($urandom % 5) != 0;
            end
        endcase
    endtask

    // One bit period, with every check at its settled cycle.
    task automatic bit_period();
        @(negedge clk);
        check(rx_overrun == exp_ovr, "R11", "rx_overrun", 32'(rx_overrun), 32'(exp_ovr));
        check(rx_valid == 1'b0, "R10", "rx_valid single cycle", 32'(rx_valid), 32'd0);
        bclk_fall = 1'b1;
        #1;
        check(tx_ready == (bpos == 63), "R7", "tx_ready", 32'(tx_ready), 32'(bpos == 63));
        @(negedge clk);
        bclk_fall = 1'b0;
        bpos = (bpos + 1) % 64;
        if (bpos == 0) begin
            fmt_frame = fmt_sel;
            tx_frame  = tx_valid ? tx_data : 32'd0;
            rx_frame  = rx_next;
            check(tx_underrun == !tx_valid, "R8", "tx_underrun at frame start",
                  32'(tx_underrun), 32'(!tx_valid));
            frame_no = frame_no + 1;
        end else begin
            check(tx_underrun == 1'b0, "R8", "tx_underrun mid frame", 32'(tx_underrun), 32'd0);
        end
        check(ser_sync == ref_sync(bpos, fmt_frame), fmt_frame ? "R4" : "R3",
              "ser_sync", 32'(ser_sync), 32'(ref_sync(bpos, fmt_frame)));
        check(ser_dout == ref_bit(tx_frame, bpos, fmt_frame), "R6",
              $sformatf("ser_dout pos %0d fmt %0d (R1 R5)", bpos, fmt_frame),
              32'(ser_dout), 32'(ref_bit(tx_frame, bpos, fmt_frame)));
        // The next frame's inputs change mid frame (R5 and R7 keep them inert).
        if (bpos == 40) prepare(frame_no);
        ser_din = ref_bit(rx_frame, bpos, fmt_frame);
        @(negedge clk);
        bclk_rise = 1'b1;
        @(negedge clk);
        bclk_rise = 1'b0;
        check(rx_valid == ref_last(bpos, fmt_frame), "R10", "rx_valid",
              32'(rx_valid), 32'(ref_last(bpos, fmt_frame)));
        if (ref_last(bpos, fmt_frame)) begin
            check(rx_data == rx_frame, "R9", "rx_data word (R1 layout)", rx_data, rx_frame);
        end
        exp_ovr = ref_last(bpos, fmt_frame) && !rx_ready;
    endtask

    initial begin
        void'($urandom(32'h5EED_A0D1));
        rst_n = 1'b0; bclk_rise = 1'b0; bclk_fall = 1'b0; ser_din = 1'b0;
        fmt_sel = 1'b0; tx_valid = 1'b0; tx_data = '0; rx_ready = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state.
        check(ser_sync == 1'b1, "R12", "ser_sync reset", 32'(ser_sync), 32'd1);
        check(ser_dout == 1'b0, "R12", "ser_dout reset", 32'(ser_dout), 32'd0);
        check(rx_valid == 1'b0, "R12", "rx_valid reset", 32'(rx_valid), 32'd0);
        check(tx_underrun == 1'b0, "R12", "tx_underrun reset", 32'(tx_underrun), 32'd0);
        check(rx_overrun == 1'b0, "R12", "rx_overrun reset", 32'(rx_overrun), 32'd0);
        check(tx_ready == 1'b0, "R12", "tx_ready reset", 32'(tx_ready), 32'd0);
        prepare(0);
        // R2: frames of 64 bit periods, over 34 frames.
        for (int i = 0; i < 34 * 64; i++) begin
            bit_period();
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule